// File: doc/BRIEF.md
# Parallel Port Transfer FIFO with Service Request

This block is the byte queue that sits between a host bus and the data lines of an extended-capability parallel port. The host can load bytes, and the peripheral side can load bytes too. Both sides share one write path, and the host wins if both load in the same cycle. Bytes always leave from the head of the queue, in the order they came in, whatever the transfer direction.

The block also decides when software needs attention. A service flag (`svc_flag`) gates both interrupts and DMA. Software clears the flag to arm the block. Hardware sets it again when a service event occurs, and at that moment a one-cycle interrupt pulse is emitted.

The kind of service event depends on the mode:
- With DMA enabled, the only event is a terminal count.
- With DMA disabled and data moving toward the peripheral, the event is occupancy falling to the drain threshold or below.
- With DMA disabled and data moving toward the host, the event is occupancy rising to the fill threshold or above.

The DMA request follows the DMA enable, the service flag and the FIFO flags, with no added delay.

Top module: `ppfifo_svc`

## Requirements
- R1: After reset `empty`=1, `full`=0, `svc_flag`=1 (service disarmed), `irq`=0 and `dma_req`=0.
- R2: `rd_data` always shows the oldest stored byte, and `pop` removes it. Bytes come out in write order for both values of `dir`: loading 44h, 33h, 22h yields 44h, 33h, 22h.
- R3: With DEPTH=16, `full` rises after 16 stored bytes. A load while full is dropped, and the stored contents are unchanged.
- R4: A `pop` while empty is ignored. `empty` stays 1, and a later load is read back correctly.
- R5: When `host_wr` and `per_push` are both asserted in one cycle, only `host_wdata` is stored. A lone `per_push` stores `per_wdata`.
- R6: With `dir`=0 (toward peripheral), `dma_en`=0 and `svc_flag`=0, occupancy reaching 8 or less causes the following:
  - one edge later, `svc_flag` becomes 1;
  - at that same edge, `irq` pulses high for exactly one cycle.
- R7: With `dir`=1 (toward host), `dma_en`=0 and `svc_flag`=0, occupancy reaching 8 or more causes the same flag set and one-cycle pulse.
- R8: While `svc_flag`=1, `irq` stays 0 and `dma_req` stays 0, whatever the occupancy.
- R9: A software write (`svc_wr`) of 1 never produces a pulse, even when it lands in the cycle in which hardware would have set the flag. A write of 0 while the service condition holds re-arms the block, and a pulse follows.
- R10: `dma_req` = `dma_en` & !`svc_flag` & (`dir`=0 ? !`full` : !`empty`), combinationally in the same cycle.
- R11: With `dma_en`=1 the occupancy thresholds are ignored. `dma_ack` & `dma_tc` with the flag clear sets `svc_flag` and pulses `irq` at that edge.
- R12: With `dma_en`=0, `dma_req` is 0 unconditionally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host byte load strobe |
| host_wdata | input | 8 | Host byte |
| per_push | input | 1 | Peripheral-side byte load strobe |
| per_wdata | input | 8 | Peripheral-side byte |
| pop | input | 1 | Remove the head byte |
| rd_data | output | 8 | Head byte |
| dir | input | 1 | 0: toward peripheral, 1: toward host |
| dma_en | input | 1 | DMA enable |
| svc_wr | input | 1 | Software write strobe for the service flag |
| svc_wdata | input | 1 | Value written to the service flag |
| svc_flag | output | 1 | Service flag (1 = interrupts and DMA blocked) |
| dma_ack | input | 1 | DMA acknowledge |
| dma_tc | input | 1 | Terminal count, qualified by `dma_ack` |
| dma_req | output | 1 | DMA request |
| full | output | 1 | FIFO holds DEPTH bytes |
| empty | output | 1 | FIFO holds no bytes |
| irq | output | 1 | One-cycle service interrupt pulse |

## Verification
Each result has its own due time:
- **FIFO state.** Loads and pops change `full`, `empty` and `rd_data` at the same clock edge that samples the strobe.
- **Occupancy-driven pulse.** This pulse appears one edge later than that, because the threshold compare reads the registered count. The pulse and the flag set land together.
- **Terminal-count pulse.** This pulse and the flag set appear at the very edge that samples `dma_ack` and `dma_tc`.
- **DMA request.** `dma_req` has no register, so it is checked in the same cycle as its inputs.

The bench drives every input 1 ns after a rising edge and samples 1 ns or 2 ns after that edge. It then steps edge by edge through these latencies. For each pulse it checks the cycle before, the pulse cycle, and the cycle after.

// File: rtl/ppfifo_pkg.sv
package ppfifo_pkg;

    typedef enum logic {
        DIR_TO_PERIPH = 1'b0,
        DIR_TO_HOST   = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic svc;
        logic irq;
    } svc_state_t;

endpackage

// File: rtl/ppfifo_push_sel.sv
module ppfifo_push_sel #(
    parameter int W = 8
) (
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    input  logic         per_push,
    input  logic [W-1:0] per_wdata,
    output logic         push,
    output logic [W-1:0] push_data
);

    // host side takes precedence when both sides load in one cycle
    always_comb begin
        push      = host_wr | per_push;
        push_data = host_wr ? host_wdata : per_wdata;
    end

endmodule

// File: rtl/ppfifo_store.sv
module ppfifo_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t         s_d, s_q;
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        mem_d   = mem_q;
        do_push = push & (s_q.cnt != CW'(DEPTH));
        do_pop  = pop & (s_q.cnt != '0);

        if (do_push) begin
            mem_d[s_q.wptr] = push_data;
            s_d.wptr = (s_q.wptr == AW'(DEPTH - 1)) ? '0 : s_q.wptr + 1'b1;
        end

        if (do_pop) begin
            s_d.rptr = (s_q.rptr == AW'(DEPTH - 1)) ? '0 : s_q.rptr + 1'b1;
        end

        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            s_q   <= s_d;
            mem_q <= mem_d;
        end
    end

    assign head_data = mem_q[s_q.rptr];
    assign count     = s_q.cnt;
    assign full      = (s_q.cnt == CW'(DEPTH));
    assign empty     = (s_q.cnt == '0);

endmodule

// File: rtl/ppfifo_svc_ctrl.sv
module ppfifo_svc_ctrl
    import ppfifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WR_TH  = 8,
    parameter int RD_TH  = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          full,
    input  logic          empty,
    input  logic          dir,
    input  logic          dma_en,
    input  logic          dma_ack,
    input  logic          dma_tc,
    input  logic          svc_wr,
    input  logic          svc_wdata,
    output logic          svc_flag,
    output logic          irq,
    output logic          dma_req
);

    svc_state_t st_d, st_q;
    xfer_dir_e  dir_e;
    logic       level_hit, tc_hit, cond;

    always_comb begin
        dir_e     = xfer_dir_e'(dir);
        level_hit = (dir_e == DIR_TO_HOST) ? (count >= CW'(RD_TH))
                                           : (count <= CW'(WR_TH));
        tc_hit    = dma_ack & dma_tc;
        cond      = dma_en ? tc_hit : level_hit;

        st_d     = st_q;
        st_d.irq = 1'b0;
        if (svc_wr) begin
            // software write wins and never raises a pulse
            st_d.svc = svc_wdata;
        end else if (!st_q.svc && cond) begin
            st_d.svc = 1'b1;
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{svc: 1'b1, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign svc_flag = st_q.svc;
    assign irq      = st_q.irq;
    assign dma_req  = dma_en & ~st_q.svc &
                      ((xfer_dir_e'(dir) == DIR_TO_HOST) ? ~empty : ~full);

endmodule

// File: rtl/ppfifo_svc.sv
module ppfifo_svc #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int WR_TH = 8,
    parameter int RD_TH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    input  logic         per_push,
    input  logic [W-1:0] per_wdata,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    input  logic         dir,
    input  logic         dma_en,
    input  logic         svc_wr,
    input  logic         svc_wdata,
    output logic         svc_flag,
    input  logic         dma_ack,
    input  logic         dma_tc,
    output logic         dma_req,
    output logic         full,
    output logic         empty,
    output logic         irq
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          push;
    logic [W-1:0]  push_data;
    logic [CW-1:0] count;

    ppfifo_push_sel #(.W(W)) u_sel (
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .per_push   (per_push),
        .per_wdata  (per_wdata),
        .push       (push),
        .push_data  (push_data)
    );

    ppfifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head_data (rd_data),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    ppfifo_svc_ctrl #(.DEPTH(DEPTH), .WR_TH(WR_TH), .RD_TH(RD_TH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count),
        .full      (full),
        .empty     (empty),
        .dir       (dir),
        .dma_en    (dma_en),
        .dma_ack   (dma_ack),
        .dma_tc    (dma_tc),
        .svc_wr    (svc_wr),
        .svc_wdata (svc_wdata),
        .svc_flag  (svc_flag),
        .irq       (irq),
        .dma_req   (dma_req)
    );

endmodule

// File: rtl/ppfifo_svc_chk.sv
module ppfifo_svc_chk (
    input logic clk,
    input logic rst_n,
    input logic host_wr,
    input logic per_push,
    input logic pop,
    input logic dma_en,
    input logic svc_wr,
    input logic svc_wdata,
    input logic svc_flag,
    input logic dma_req,
    input logic full,
    input logic empty,
    input logic irq
);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> svc_flag);

    p_irq_needs_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(!svc_flag));

    p_no_dma_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        svc_flag |-> !dma_req);

    p_no_dma_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);

    p_sw_set_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && svc_wdata) |=> !irq);

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

    p_empty_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !host_wr && !per_push) |=> empty);

endmodule

bind ppfifo_svc ppfifo_svc_chk u_chk (.*);

// File: tb/test_ppfifo_svc.sv
`timescale 1ns/1ps
module test_ppfifo_svc;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_wr, per_push, pop, dir, dma_en, svc_wr, svc_wdata, dma_ack, dma_tc;
    logic [7:0] host_wdata, per_wdata, rd_data;
    logic       svc_flag, dma_req, full, empty, irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ppfifo_svc i_ppfifo_svc (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .per_push(per_push), .per_wdata(per_wdata),
        .pop(pop), .rd_data(rd_data), .dir(dir), .dma_en(dma_en),
        .svc_wr(svc_wr), .svc_wdata(svc_wdata), .svc_flag(svc_flag),
        .dma_ack(dma_ack), .dma_tc(dma_tc), .dma_req(dma_req),
        .full(full), .empty(empty), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        host_wr = 0; per_push = 0; pop = 0; svc_wr = 0; svc_wdata = 0;
        dma_ack = 0; dma_tc = 0; host_wdata = 0; per_wdata = 0;
    endtask

    task automatic do_reset();
        idle();
        dir = 0; dma_en = 0;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic load(input logic [7:0] b);
        host_wr = 1; host_wdata = b;
        tick();
        host_wr = 0;
    endtask

    task automatic take(input string req, input logic [7:0] exp);
        chk(req, rd_data, exp);
        pop = 1;
        tick();
        pop = 0;
    endtask

    task automatic set_svc(input logic v);
        svc_wr = 1; svc_wdata = v;
        tick();
        svc_wr = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 svc_flag", svc_flag, 1);
        chk("R1 irq", irq, 0);
        chk("R1 dma_req", dma_req, 0);
    endtask

    task automatic t_order();
        for (int d = 0; d < 2; d++) begin
            do_reset();
            dir = d[0];
            load(8'h44); load(8'h33); load(8'h22);
            take("R2 head0", 8'h44);
            take("R2 head1", 8'h33);
            take("R2 head2", 8'h22);
            chk("R2 empty after drain", empty, 1);
        end
    endtask

    task automatic t_full();
        do_reset();
        dir = 1;
        for (int i = 0; i < 16; i++) load(8'(i * 3 + 1));
        chk("R3 full at 16", full, 1);
        load(8'hEE);
        chk("R3 still full", full, 1);
        for (int i = 0; i < 16; i++) take("R3 contents", 8'(i * 3 + 1));
        chk("R3 empty after drain", empty, 1);
    endtask

    task automatic t_empty_pop();
        do_reset();
        pop = 1; tick(); tick(); pop = 0;
        chk("R4 empty after pop", empty, 1);
        load(8'h5A);
        chk("R4 not empty", empty, 0);
        take("R4 read", 8'h5A);
        chk("R4 empty again", empty, 1);
    endtask

    task automatic t_priority();
        do_reset();
        host_wr = 1; host_wdata = 8'hA1; per_push = 1; per_wdata = 8'hB2;
        tick();
        host_wr = 0; per_push = 1; per_wdata = 8'hC3;
        tick();
        per_push = 0;
        take("R5 host wins", 8'hA1);
        take("R5 peripheral alone", 8'hC3);
        chk("R5 nothing else", empty, 1);
    endtask

    task automatic t_wr_thresh();
        do_reset();
        dir = 0;
        for (int i = 0; i < 10; i++) load(8'(i));
        set_svc(0);
        chk("R6 armed", svc_flag, 0);
        tick();
        chk("R6 no irq at 10", irq, 0);
        pop = 1; tick();
        chk("R6 no irq at 9", irq, 0);
        tick(); pop = 0;
        chk("R6 no irq same edge", irq, 0);
        tick();
        chk("R6 irq pulse", irq, 1);
        chk("R6 flag set", svc_flag, 1);
        tick();
        chk("R6 pulse ends", irq, 0);
    endtask

    task automatic t_rd_thresh();
        do_reset();
        dir = 1;
        set_svc(0);
        for (int i = 0; i < 7; i++) load(8'(i));
        tick();
        chk("R7 no irq at 7", irq, 0);
        chk("R7 still armed", svc_flag, 0);
        load(8'h77);
        chk("R7 no irq same edge", irq, 0);
        tick();
        chk("R7 irq pulse", irq, 1);
        chk("R7 flag set", svc_flag, 1);
        tick();
        chk("R7 pulse ends", irq, 0);
    endtask

    task automatic t_blocked();
        // continues from R7 state: flag 1, occupancy 8, dir 1
        dma_en = 1;
        #1;
        chk("R8 no dma while blocked", dma_req, 0);
        load(8'h99);
        tick(); tick();
        chk("R8 no irq while blocked", irq, 0);
        chk("R8 no dma later", dma_req, 0);
        dma_en = 0;
    endtask

    task automatic t_sw();
        do_reset();
        dir = 0;
        set_svc(1);
        chk("R9 write 1 no irq", irq, 0);
        tick();
        chk("R9 write 1 quiet", irq, 0);
        set_svc(0);
        chk("R9 cleared", svc_flag, 0);
        tick();
        chk("R9 re-arm pulse", irq, 1);
        chk("R9 re-arm flag", svc_flag, 1);
        set_svc(0);
        set_svc(1);
        chk("R9 race no irq", irq, 0);
        tick();
        chk("R9 race still quiet", irq, 0);
        chk("R9 flag held", svc_flag, 1);
    endtask

    task automatic t_dma();
        do_reset();
        dir = 0; dma_en = 1;
        set_svc(0);
        #1;
        chk("R10 req when not full", dma_req, 1);
        tick(); tick();
        chk("R11 threshold ignored flag", svc_flag, 0);
        chk("R11 threshold ignored irq", irq, 0);
        for (int i = 0; i < 16; i++) load(8'(i));
        #1;
        chk("R10 no req when full", dma_req, 0);
        pop = 1; tick(); pop = 0;
        #1;
        chk("R10 req after pop", dma_req, 1);
        dir = 1;
        #1;
        chk("R10 req dir1 not empty", dma_req, 1);
        dma_ack = 1; dma_tc = 1;
        tick();
        dma_ack = 0; dma_tc = 0;
        chk("R11 tc pulse", irq, 1);
        chk("R11 tc flag", svc_flag, 1);
        #1;
        chk("R11 req dropped", dma_req, 0);
        tick();
        chk("R11 pulse ends", irq, 0);
        do_reset();
        dir = 1; dma_en = 1;
        set_svc(0);
        #1;
        chk("R10 no req dir1 empty", dma_req, 0);
    endtask

    task automatic t_dma_off();
        do_reset();
        dir = 0; dma_en = 0;
        set_svc(0);
        #1;
        chk("R12 no req when disabled", dma_req, 0);
    endtask

    initial begin
        rst_n = 0;
        idle();
        dir = 0; dma_en = 0;
        t_reset();
        t_order();
        t_full();
        t_empty_pop();
        t_priority();
        t_wr_thresh();
        t_rd_thresh();
        t_blocked();
        t_sw();
        t_dma();
        t_dma_off();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule